// File: doc/BRIEF.md
# Converter Power and Reference Sequencer

This block sits between a serial command interface and a successive-approximation converter core. It governs two enables: one powers the converter and one powers the on-chip reference. It also hands the core a one-cycle start pulse, and it returns a done pulse and a captured result to the interface. Each conversion request carries a two-bit power mode. That mode sets the reference state right away. It also sets the converter power state to fall back to once the conversion has finished.

The block checks whether a request switches the reference, or needs the converter powered up from off. If it does, the block waits out a settling count before it issues the start pulse. Three settling counts are supplied as inputs, one for each serial bus speed (standard, fast, high speed), and a speed input selects between them. The analog conversion itself is modelled as a fixed busy interval. At the end of that interval the core's data word is latched into the result register.

Top module: `pwr_ref_seq`

## Requirements
- R1: Reset holds `ref_en`, `adc_en`, `busy`, `done`, `conv_start` and `result` at zero.
- R2: A request is accepted when `start` is high in a cycle where `busy` is low. From the edge that accepts it, `ref_en` equals `pd_mode[1]` and holds that value until a later request is accepted.
- R3: `adc_en` is high from the accepting edge through the cycle in which `done` is high. In the next cycle it equals `pd_mode[0]` of that request. With modes 00 and 10 the converter is therefore powered only around the conversion, and with modes 01 and 11 it stays on.
- R4: If the request changes `ref_en`, or finds `adc_en` low, then `conv_start` rises S+1 cycles after the accepting edge, where S is the selected settling count. Otherwise it rises in the first cycle after that edge.
- R5: `bus_spd` selects the settling count: 0 selects `settle_std`, 1 selects `settle_fast`, and 2 or 3 select `settle_hs`. A count of zero acts as one cycle.
- R6: Each accepted request produces exactly one `conv_start` pulse and one `done` pulse. `done` is high exactly CONV_CYC cycles after the cycle in which `conv_start` is high, and lasts one cycle.
- R7: `busy` is high from the cycle after the accepting edge through the `done` cycle, and low in the following cycle.
- R8: A `start` while `busy` is high is ignored. It produces no extra pulse and no extra busy interval.
- R9: `result` takes the value of `core_result` sampled at the clock edge that raises `done`. It does not change in any other cycle.
- R10: `conv_start` is never high while `adc_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request strobe |
| pd_mode | input | 2 | Power mode carried with the request: bit 1 is the reference, bit 0 keeps the converter on |
| bus_spd | input | 2 | Bus speed: 0 standard, 1 fast, 2 or 3 high speed |
| settle_std | input | CNT_W | Settling count for standard speed |
| settle_fast | input | CNT_W | Settling count for fast speed |
| settle_hs | input | CNT_W | Settling count for high speed |
| core_result | input | DW | Data word from the converter core |
| ref_en | output | 1 | Internal reference enable |
| adc_en | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle start pulse to the core |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Captured conversion result |

## Verification
The assertions assume that `start`, `pd_mode` and `bus_spd` are driven synchronously and that they hold valid values in the accepting cycle. They also assume the three settling counts stay constant while a settling wait runs, so that the selected count cannot move under the timer. The stimulus changes those counts only between requests, while `busy` is low. It raises `start` for single cycles only, and the bench drives every input on the falling clock edge.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_CONV   = 2'd2,
      SQ_DONE   = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      SPD_STD  = 2'd0,
      SPD_FAST = 2'd1,
      SPD_HS   = 2'd2
   } bus_speed_t;

   localparam int MODE_W = 2;
   localparam int MODE_REF_BIT = 1;
   localparam int MODE_ADC_BIT = 0;
endpackage

// File: rtl/pwrseq_settle_timer.sv
module pwrseq_settle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [1:0]       spd,
   input  logic [CNT_W-1:0] cnt_std,
   input  logic [CNT_W-1:0] cnt_fast,
   input  logic [CNT_W-1:0] cnt_hs,
   output logic             last
);
   import pwrseq_pkg::*;

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] sel_cnt;
   logic [CNT_W-1:0] eff_cnt;
   logic [CNT_W-1:0] cnt_q;
   logic             active_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pwrseq_settle_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      case (spd)
         SPD_STD:  sel_cnt = cnt_std;
         SPD_FAST: sel_cnt = cnt_fast;
         default:  sel_cnt = cnt_hs;
      endcase
      eff_cnt = (sel_cnt == '0) ? ONE : sel_cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         cnt_q    <= eff_cnt;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (cnt_q == ONE) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign last = active_q && (cnt_q == ONE);

   // R5: a running wait never holds a zero count
   a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q != '0));

   // R4: the wait counts down by one per cycle until it expires
   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !last && !load) |=> (active_q && cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/pwrseq_conv_model.sv
module pwrseq_conv_model #(
   parameter int DW       = 8,
   parameter int CONV_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_go,
   input  logic [DW-1:0] core_data,
   output logic          conv_last,
   output logic [DW-1:0] result
);
   localparam int CCW = (CONV_CYC > 1) ? $clog2(CONV_CYC + 1) : 1;

   logic [DW-1:0] result_q;

   generate
      if (CONV_CYC < 1) begin : g_bad_len
         $error("pwrseq_conv_model: CONV_CYC must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("pwrseq_conv_model: DW must be at least 1");
      end

      if (CONV_CYC == 1) begin : g_single
         assign conv_last = conv_go;
      end else begin : g_counted
         logic [CCW-1:0] cnt_q;
         logic           run_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (conv_go) begin
               cnt_q <= CCW'(CONV_CYC - 1);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (cnt_q == CCW'(1)) begin
                  run_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - CCW'(1);
               end
            end
         end

         assign conv_last = run_q && (cnt_q == CCW'(1));

         // R6: a new start never lands on a running conversion
         a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            conv_go |-> !run_q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
      end else if (conv_last) begin
         result_q <= core_data;
      end
   end

   assign result = result_q;
endmodule

// File: rtl/pwr_ref_seq.sv
module pwr_ref_seq #(
   parameter int DW       = 8,
   parameter int CNT_W    = 8,
   parameter int CONV_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       pd_mode,
   input  logic [1:0]       bus_spd,
   input  logic [CNT_W-1:0] settle_std,
   input  logic [CNT_W-1:0] settle_fast,
   input  logic [CNT_W-1:0] settle_hs,
   input  logic [DW-1:0]    core_result,
   output logic             ref_en,
   output logic             adc_en,
   output logic             conv_start,
   output logic             busy,
   output logic             done,
   output logic [DW-1:0]    result
);
   import pwrseq_pkg::*;

   seq_state_t        state_q;
   logic [MODE_W-1:0] mode_q;
   logic              ref_q;
   logic              adc_q;
   logic              go_q;
   logic              done_q;
   logic              accept;
   logic              need_settle;
   logic              settle_last;
   logic              conv_last;

   assign accept      = (state_q == SQ_IDLE) && start;
   assign need_settle = (pd_mode[MODE_REF_BIT] != ref_q) || !adc_q;

   pwrseq_settle_timer #(
      .CNT_W (CNT_W)
   ) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && need_settle),
      .spd      (bus_spd),
      .cnt_std  (settle_std),
      .cnt_fast (settle_fast),
      .cnt_hs   (settle_hs),
      .last     (settle_last)
   );

   pwrseq_conv_model #(
      .DW       (DW),
      .CONV_CYC (CONV_CYC)
   ) u_conv (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_go   (go_q),
      .core_data (core_result),
      .conv_last (conv_last),
      .result    (result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= '0;
         ref_q   <= 1'b0;
         adc_q   <= 1'b0;
         go_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  mode_q <= pd_mode;
                  ref_q  <= pd_mode[MODE_REF_BIT];
                  adc_q  <= 1'b1;
                  if (need_settle) begin
                     state_q <= SQ_SETTLE;
                  end else begin
                     state_q <= SQ_CONV;
                     go_q    <= 1'b1;
                  end
               end
            end
            SQ_SETTLE: begin
               if (settle_last) begin
                  state_q <= SQ_CONV;
                  go_q    <= 1'b1;
               end
            end
            SQ_CONV: begin
               if (conv_last) begin
                  state_q <= SQ_DONE;
                  done_q  <= 1'b1;
               end
            end
            default: begin
               state_q <= SQ_IDLE;
               adc_q   <= mode_q[MODE_ADC_BIT];
            end
         endcase
      end
   end

   assign ref_en     = ref_q;
   assign adc_en     = adc_q;
   assign conv_start = go_q;
   assign busy       = (state_q != SQ_IDLE);
   assign done       = done_q;

   // R10: the core is never started unpowered
   a_r10_start_powered: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> adc_en);

   // R6: done is a single-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: busy covers the done cycle and drops right after it
   a_r7_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy ##1 !busy);

   // R9: the result moves only together with done
   a_r9_result_atomic: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R3: converter power falls back to the requested mode after done
   a_r3_power_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (adc_en == $past(mode_q[MODE_ADC_BIT])));

   // R2: the reference only moves on an accepted request
   a_r2_ref_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(ref_en));

   // R8: a start while busy never restarts the sequence
   a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !done) |=> busy);
endmodule

// File: tb/pwr_ref_seq_bench.sv
module pwr_ref_seq_bench;
   localparam int DW    = 8;
   localparam int CNT_W = 8;
   localparam int CONV  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       pd_mode = '0;
   logic [1:0]       bus_spd = '0;
   logic [CNT_W-1:0] settle_std = 8'd5;
   logic [CNT_W-1:0] settle_fast = 8'd3;
   logic [CNT_W-1:0] settle_hs = 8'd2;
   logic [DW-1:0]    core_result = '0;
   logic             ref_en, adc_en, conv_start, busy, done;
   logic [DW-1:0]    result;

   int  errors = 0;
   int  checks = 0;
   int  cycles = 0;
   bit  finished = 1'b0;
   int  salt = 0;
   bit  ref_m = 1'b0;
   bit  adc_m = 1'b0;
   logic [DW-1:0] prev_res = '0;

   always #4 clk = ~clk;

   pwr_ref_seq #(.DW(DW), .CNT_W(CNT_W), .CONV_CYC(CONV)) u_pwr_ref_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .pd_mode (pd_mode),
      .bus_spd (bus_spd), .settle_std (settle_std), .settle_fast (settle_fast),
      .settle_hs (settle_hs), .core_result (core_result), .ref_en (ref_en),
      .adc_en (adc_en), .conv_start (conv_start), .busy (busy), .done (done),
      .result (result)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int k);
      return DW'(k * 29 + salt * 11 + 5);
   endfunction

   function automatic int sel_settle(input logic [1:0] spd);
      int v;
      case (spd)
         2'd0: v = int'(settle_std);
         2'd1: v = int'(settle_fast);
         default: v = int'(settle_hs);
      endcase
      return (v == 0) ? 1 : v;
   endfunction

   task automatic run_txn(input logic [1:0] pd, input logic [1:0] spd, input bit poke);
      bit need;
      int kcs_exp, kd_exp, kcs, kd, n_cs, n_done;
      bit busy_ok, pwr_ok, hold_ok;
      logic [DW-1:0] exp_res;
      salt++;
      need    = (ref_m != pd[1]) || !adc_m;
      kcs_exp = need ? sel_settle(spd) + 1 : 1;
      kd_exp  = kcs_exp + CONV;
      exp_res = pat(kd_exp - 1);
      kcs = -1; kd = -1; n_cs = 0; n_done = 0;
      busy_ok = 1'b1; pwr_ok = 1'b1; hold_ok = 1'b1;
      @(negedge clk);
      pd_mode = pd; bus_spd = spd; start = 1'b1; core_result = pat(0);
      for (int k = 1; k <= kd_exp + 1; k++) begin
         @(negedge clk);
         start = poke && (k == 2);
         if (conv_start) begin n_cs++; if (kcs < 0) kcs = k; end
         if (done) begin n_done++; if (kd < 0) kd = k; end
         if (k <= kd_exp) begin
            if (!busy) busy_ok = 1'b0;
            if (!adc_en || ref_en != pd[1]) pwr_ok = 1'b0;
            if (k < kd_exp && result != prev_res) hold_ok = 1'b0;
         end else begin
            chk(!busy, "R7 busy low after done", busy, 0);
            chk(adc_en == pd[0], "R3 adc power after done", adc_en, pd[0]);
            chk(ref_en == pd[1], "R2 reference level", ref_en, pd[1]);
         end
         core_result = pat(k);
      end
      chk(kcs == kcs_exp, need ? "R4/R5 start after settling" : "R4 start without settling", kcs, kcs_exp);
      chk(kd == kd_exp, "R6 done latency", kd, kd_exp);
      chk(n_cs == 1 && n_done == 1, "R6 one start and one done", n_cs * 10 + n_done, 11);
      chk(busy_ok, "R7 busy through done", busy_ok, 1);
      chk(pwr_ok, "R3 adc on and R2 ref during request", pwr_ok, 1);
      chk(hold_ok, "R9 result held before done", hold_ok, 1);
      chk(result == exp_res, "R9 result capture", result, exp_res);
      prev_res = result;
      ref_m = pd[1];
      adc_m = pd[0];
      if (poke) begin
         bit quiet;
         quiet = 1'b1;
         for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (busy || done || conv_start) quiet = 1'b0;
         end
         chk(quiet, "R8 start while busy ignored", quiet, 1);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!ref_en && !adc_en && !busy && !done && !conv_start, "R1 reset outputs",
          {ref_en, adc_en, busy, done, conv_start}, 0);
      chk(result == '0, "R1 reset result", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ref_en && !adc_en && !busy, "R1 idle after reset", {ref_en, adc_en, busy}, 0);

      // R2 R3 R4 R5 R6 R7 R9: sweep every mode pair at every bus speed
      for (int pa = 0; pa < 4; pa++) begin
         for (int pb = 0; pb < 4; pb++) begin
            for (int sp = 0; sp < 4; sp++) begin
               run_txn(2'(pa), 2'(sp), 1'b0);
               run_txn(2'(pb), 2'(sp), 1'b0);
            end
         end
      end

      // R8: extra start pulses during a request
      run_txn(2'b00, 2'd1, 1'b1);
      run_txn(2'b11, 2'd0, 1'b1);
      run_txn(2'b11, 2'd2, 1'b1);

      // R5: a zero count acts as one cycle
      settle_hs = '0;
      run_txn(2'b01, 2'd2, 1'b0);
      run_txn(2'b10, 2'd3, 1'b0);
      settle_fast = 8'd9;
      run_txn(2'b11, 2'd1, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule